// File: doc/BRIEF.md
# Vector Compare-to-Predicate Unit

This block reads 32-bit integer conditional-branch words and decides from a per-register length table whether to treat each one as an ordinary branch or as an element-wise vector compare. The decision does not come from the opcode. When neither source register carries a length, the unit only raises a one-cycle scalar-branch flag. Redirecting the program counter is left to the surrounding pipeline.

When at least one source is marked as a vector, the unit steps through the elements at one per clock. It reads each operand pair from its own register-file model, applies the signed or unsigned compare selected by funct3, and collects one result bit per element. After the last element it writes the assembled bitmask to the register named in bits 11..7 of the word, in a single cycle.

The length table and the register file are loaded through plain write ports. A separate read port lets the surrounding logic inspect any register.

Top module: `vec_pred_cmp`

## Requirements
- R1: The length table has one 4-bit entry per register and is written through cfgWe/cfgIdx/cfgLen. After reset every entry is 0, so any branch word is reported as a scalar branch.
- R2: A word with bits 6..0 = 1100011 whose rs1 (bits 19..15) and rs2 (bits 24..20) both have length 0 raises scalarBranch for exactly the cycle after the accepting edge. It does not make the unit busy and writes no register.
- R3: A word whose bits 6..0 differ from 1100011 is ignored: no flag, no busy, no register write.
- R4: When either source length is non-zero, the vector length VL is the larger of the two lengths. The unit is busy from the accepting edge on. done is high for one cycle, starting VL clock edges after the accepting edge, and the target register is written at the edge that ends that cycle, after which busy is low.
- R5: Element i of a source with non-zero length N at register r is register (r+i) mod 32.
- R6: A source with length 0 supplies its single value to every element, whether it is rs1 or rs2.
- R7: funct3 selects the compare rs1-element against rs2-element: 000 equal, 001 not equal, 100 signed less than, 101 signed greater or equal, 110 unsigned less than, 111 unsigned greater or equal. Swapping rs1 and rs2 gives the reversed relations.
- R8: In vector mode, funct3 010 or 011, or any non-zero bit in 31..25, raises illegalOp for the cycle after the accepting edge. The unit does not become busy and writes nothing.
- R9: Bit i of the written predicate is the result for element i. All bits at and above VL are written as 0, whatever the target held before.
- R10: Register 0 always reads as zero. Writes to it from the load port or from a predicate result are discarded.
- R11: A length of 1 counts as a vector and gives a one-element compare with a one-bit predicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Length-table write enable |
| cfgIdx | input | 5 | Length-table entry to write |
| cfgLen | input | 4 | Length value to write |
| rfWe | input | 1 | Register-file load enable |
| rfWaddr | input | 5 | Register-file load address |
| rfWdata | input | 32 | Register-file load data |
| rfRaddr | input | 5 | Inspection read address |
| rfRdata | output | 32 | Inspection read data |
| instValid | input | 1 | Branch word present; taken only while not busy |
| instWord | input | 32 | Instruction word |
| busy | output | 1 | Element walk or write in progress |
| done | output | 1 | Predicate write happens at the end of this cycle |
| scalarBranch | output | 1 | Pulse: word is an ordinary scalar branch |
| illegalOp | output | 1 | Pulse: vector compare with a bad encoding |

## Verification
The bench places a negative value in one lane, so that the signed and unsigned compares give different results. A swapped signed/unsigned decode would flip that lane's bit. The target registers are pre-filled with all ones, which exposes a design that fails to clear the bits above VL. One vector runs from register 30 through register 1, so a design that does not wrap the index, or that reads register 0 as stored data, gives the wrong mask. Other cases use sources of unequal length, a scalar on either side, a length of 1, and illegal encodings. Counting the edges up to done catches walks that are one element short or one element long.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  localparam int VPC_LENW = 4;

  typedef enum logic [2:0] {
    CMP_EQ  = 3'b000,
    CMP_NE  = 3'b001,
    CMP_BAD2 = 3'b010,
    CMP_BAD3 = 3'b011,
    CMP_LT  = 3'b100,
    CMP_GE  = 3'b101,
    CMP_LTU = 3'b110,
    CMP_GEU = 3'b111
  } cmpOp_e;

  typedef struct packed {
    logic                latchInst;
    logic                clearAcc;
    logic                stepElem;
    logic                writePred;
    logic [VPC_LENW-1:0] elemIdx;
  } vpcStrobes_t;
endpackage

// File: rtl/vpc_ctrl.sv
module vpc_ctrl
  import vpc_pkg::*;
#(
  parameter int LENW = VPC_LENW
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instValid,
  input  logic [6:0]      opField,
  input  logic [2:0]      f3Field,
  input  logic [6:0]      rsvdField,
  input  logic [LENW-1:0] lenA,
  input  logic [LENW-1:0] lenB,
  output vpcStrobes_t     strb,
  output logic            busy,
  output logic            done,
  output logic            scalarBranch,
  output logic            illegalOp
);
  localparam logic [6:0] BRANCH_OP = 7'b1100011;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WRITE} state_e;

  state_e          stateQ;
  logic [LENW-1:0] idxQ;
  logic [LENW-1:0] vlQ;
  logic            accept;
  logic            isVec;
  logic            badEnc;
  logic            startRun;
  logic [LENW-1:0] vlNext;

  assign accept   = (stateQ == S_IDLE) && instValid && (opField == BRANCH_OP);
  assign isVec    = (lenA != '0) || (lenB != '0);
  assign badEnc   = (f3Field == CMP_BAD2) || (f3Field == CMP_BAD3) || (rsvdField != '0);
  assign startRun = accept && isVec && !badEnc;
  assign vlNext   = (lenA > lenB) ? lenA : lenB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ       <= S_IDLE;
      idxQ         <= '0;
      vlQ          <= '0;
      scalarBranch <= 1'b0;
      illegalOp    <= 1'b0;
    end else begin
      scalarBranch <= accept && !isVec;
      illegalOp    <= accept && isVec && badEnc;
      unique case (stateQ)
        S_IDLE: if (startRun) begin
          stateQ <= S_RUN;
          idxQ   <= '0;
          vlQ    <= vlNext;
        end
        S_RUN: begin
          if (idxQ == vlQ - 1'b1) stateQ <= S_WRITE;
          else idxQ <= idxQ + 1'b1;
        end
        S_WRITE: stateQ <= S_IDLE;
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.latchInst = startRun;
    strb.clearAcc  = startRun;
    strb.stepElem  = (stateQ == S_RUN);
    strb.writePred = (stateQ == S_WRITE);
    strb.elemIdx   = idxQ;
  end

  assign busy = (stateQ != S_IDLE);
  assign done = (stateQ == S_WRITE);
endmodule

// File: rtl/vpc_datapath.sv
module vpc_datapath
  import vpc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int LENW = VPC_LENW,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWe,
  input  logic [RW-1:0]   cfgIdx,
  input  logic [LENW-1:0] cfgLen,
  input  logic            rfWe,
  input  logic [RW-1:0]   rfWaddr,
  input  logic [XLEN-1:0] rfWdata,
  input  logic [RW-1:0]   rfRaddr,
  output logic [XLEN-1:0] rfRdata,
  input  logic [RW-1:0]   rs1Field,
  input  logic [RW-1:0]   rs2Field,
  input  logic [RW-1:0]   rdField,
  input  logic [2:0]      f3Field,
  input  vpcStrobes_t     strb,
  output logic [LENW-1:0] lenA,
  output logic [LENW-1:0] lenB
);
  logic [LENW-1:0] lenTab [NREG];
  logic [XLEN-1:0] regs   [NREG];
  logic [RW-1:0]   rs1Q, rs2Q, rdQ;
  logic [2:0]      f3Q;
  logic            vecAQ, vecBQ;
  logic [XLEN-1:0] predAcc;
  logic [RW-1:0]   idxExt;
  logic [RW-1:0]   addrA, addrB;
  logic [XLEN-1:0] opA, opB;
  logic            cmpRes;

  function automatic logic [XLEN-1:0] rdReg(input logic [RW-1:0] a);
    return (a == '0) ? '0 : regs[a];
  endfunction

  assign lenA    = lenTab[rs1Field];
  assign lenB    = lenTab[rs2Field];
  assign rfRdata = rdReg(rfRaddr);

  assign idxExt = RW'(strb.elemIdx);
  assign addrA  = vecAQ ? rs1Q + idxExt : rs1Q;
  assign addrB  = vecBQ ? rs2Q + idxExt : rs2Q;
  assign opA    = rdReg(addrA);
  assign opB    = rdReg(addrB);

  always_comb begin
    unique case (f3Q)
      CMP_EQ:  cmpRes = (opA == opB);
      CMP_NE:  cmpRes = (opA != opB);
      CMP_LT:  cmpRes = ($signed(opA) <  $signed(opB));
      CMP_GE:  cmpRes = ($signed(opA) >= $signed(opB));
      CMP_LTU: cmpRes = (opA <  opB);
      CMP_GEU: cmpRes = (opA >= opB);
      default: cmpRes = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rs1Q    <= '0;
      rs2Q    <= '0;
      rdQ     <= '0;
      f3Q     <= '0;
      vecAQ   <= 1'b0;
      vecBQ   <= 1'b0;
      predAcc <= '0;
    end else begin
      if (strb.latchInst) begin
        rs1Q  <= rs1Field;
        rs2Q  <= rs2Field;
        rdQ   <= rdField;
        f3Q   <= f3Field;
        vecAQ <= (lenA != '0);
        vecBQ <= (lenB != '0);
      end
      if (strb.clearAcc) predAcc <= '0;
      else if (strb.stepElem) predAcc[strb.elemIdx] <= cmpRes;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lenTab[g] <= '0;
        regs[g]   <= '0;
      end else begin
        if (cfgWe && cfgIdx == RW'(g)) lenTab[g] <= cfgLen;
        if (g != 0) begin
          if (strb.writePred && rdQ == RW'(g)) regs[g] <= predAcc;
          else if (rfWe && rfWaddr == RW'(g)) regs[g] <= rfWdata;
        end
      end
    end
  end
endmodule

// File: rtl/vec_pred_cmp.sv
module vec_pred_cmp
  import vpc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int LENW = VPC_LENW,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWe,
  input  logic [RW-1:0]   cfgIdx,
  input  logic [LENW-1:0] cfgLen,
  input  logic            rfWe,
  input  logic [RW-1:0]   rfWaddr,
  input  logic [XLEN-1:0] rfWdata,
  input  logic [RW-1:0]   rfRaddr,
  output logic [XLEN-1:0] rfRdata,
  input  logic            instValid,
  input  logic [31:0]     instWord,
  output logic            busy,
  output logic            done,
  output logic            scalarBranch,
  output logic            illegalOp
);
  vpcStrobes_t     strb;
  logic [LENW-1:0] lenA, lenB;

  vpc_ctrl #(.LENW(LENW)) u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid),
    .opField(instWord[6:0]), .f3Field(instWord[14:12]),
    .rsvdField(instWord[31:25]), .lenA(lenA), .lenB(lenB),
    .strb(strb), .busy(busy), .done(done),
    .scalarBranch(scalarBranch), .illegalOp(illegalOp)
  );

  vpc_datapath #(.XLEN(XLEN), .NREG(NREG), .LENW(LENW)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgLen(cfgLen),
    .rfWe(rfWe), .rfWaddr(rfWaddr), .rfWdata(rfWdata),
    .rfRaddr(rfRaddr), .rfRdata(rfRdata),
    .rs1Field(instWord[15+RW-1:15]), .rs2Field(instWord[20+RW-1:20]),
    .rdField(instWord[7+RW-1:7]), .f3Field(instWord[14:12]),
    .strb(strb), .lenA(lenA), .lenB(lenB)
  );
endmodule

// File: rtl/vec_pred_cmp_chk.sv
module vec_pred_cmp_chk #(
  parameter int XLEN = 32,
  parameter int RW   = 5
) (
  input logic            clk,
  input logic            rstN,
  input logic [RW-1:0]   rfRaddr,
  input logic [XLEN-1:0] rfRdata,
  input logic            busy,
  input logic            done,
  input logic            scalarBranch,
  input logic            illegalOp
);
  a_r2_scalar_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    scalarBranch |-> !busy);
  a_r8_illegal_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> !busy);
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  a_r4_done_inside_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  a_r4_busy_falls_after_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));
  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, scalarBranch, illegalOp}));
  a_r10_x0_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rfRaddr == '0) |-> (rfRdata == '0));
endmodule

bind vec_pred_cmp vec_pred_cmp_chk #(.XLEN(XLEN), .RW(RW)) u_chk (.*);

// File: tb/sim_vec_pred_cmp.sv
module sim_vec_pred_cmp;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWe = 1'b0;
  logic [4:0]  cfgIdx = '0;
  logic [3:0]  cfgLen = '0;
  logic        rfWe = 1'b0;
  logic [4:0]  rfWaddr = '0;
  logic [31:0] rfWdata = '0;
  logic [4:0]  rfRaddr = '0;
  logic [31:0] rfRdata;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic        busy, done, scalarBranch, illegalOp;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  vec_pred_cmp u0 (.*);

  typedef struct packed {
    logic [2:0]  f3;
    logic [4:0]  a;
    logic [4:0]  b;
    logic [4:0]  d;
    logic [3:0]  vl;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{3'b000, 5'd1,  5'd8,  5'd17, 4'd4, 32'h9},
    '{3'b001, 5'd1,  5'd8,  5'd16, 4'd4, 32'h6},
    '{3'b100, 5'd1,  5'd8,  5'd16, 4'd4, 32'h6},
    '{3'b101, 5'd1,  5'd8,  5'd16, 4'd4, 32'h9},
    '{3'b110, 5'd1,  5'd8,  5'd16, 4'd4, 32'h4},
    '{3'b111, 5'd1,  5'd8,  5'd16, 4'd4, 32'hB},
    '{3'b100, 5'd8,  5'd1,  5'd16, 4'd4, 32'h0},
    '{3'b101, 5'd1,  5'd20, 5'd16, 4'd4, 32'h5},
    '{3'b100, 5'd20, 5'd1,  5'd16, 4'd4, 32'h4},
    '{3'b000, 5'd1,  5'd12, 5'd16, 4'd4, 32'h8},
    '{3'b000, 5'd30, 5'd21, 5'd16, 4'd4, 32'h4},
    '{3'b000, 5'd12, 5'd1,  5'd16, 4'd4, 32'h8},
    '{3'b111, 5'd22, 5'd21, 5'd18, 4'd1, 32'h1}
  };

  function automatic logic [31:0] brWord(input logic [6:0] hi, input logic [4:0] b,
      input logic [4:0] a, input logic [2:0] f3, input logic [4:0] d, input logic [6:0] op);
    return {hi, b, a, f3, d, op};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      finishRun();
    end
  end

  task automatic setLen(input logic [4:0] r, input logic [3:0] l);
    @(negedge clk); cfgWe = 1'b1; cfgIdx = r; cfgLen = l;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic loadReg(input logic [4:0] r, input logic [31:0] v);
    @(negedge clk); rfWe = 1'b1; rfWaddr = r; rfWdata = v;
    @(negedge clk); rfWe = 1'b0;
  endtask

  task automatic readReg(input logic [4:0] r, output logic [31:0] v);
    @(negedge clk); rfRaddr = r; #1 v = rfRdata;
  endtask

  // Present a word for one edge; returns at the negedge after the accepting edge.
  task automatic issue(input logic [31:0] w);
    @(negedge clk); instValid = 1'b1; instWord = w;
    @(posedge clk);
    @(negedge clk); instValid = 1'b0; instWord = '0;
  endtask

  // After issue: count edges until done, then let the write edge pass.
  task automatic waitDone(output int n);
    n = 0;
    while (!done && n < 40) begin
      @(posedge clk); n++; @(negedge clk);
    end
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int n;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state
    check("R4 busy after reset", {31'b0, busy}, 32'h0);
    check("R4 done after reset", {31'b0, done}, 32'h0);
    check("R2 flag after reset", {31'b0, scalarBranch | illegalOp}, 32'h0);

    loadReg(5'd1, 32'd5);  loadReg(5'd2, 32'hFFFF_FFFD);
    loadReg(5'd3, 32'd10); loadReg(5'd4, 32'd0);
    loadReg(5'd8, 32'd5);  loadReg(5'd9, 32'd2);
    loadReg(5'd10, 32'd20); loadReg(5'd11, 32'd0);
    loadReg(5'd12, 32'd7); loadReg(5'd13, 32'd1);
    loadReg(5'd20, 32'd5);
    loadReg(5'd30, 32'd1); loadReg(5'd31, 32'd2);
    loadReg(5'd22, 32'd3);
    loadReg(5'd16, 32'h1234_5678);
    loadReg(5'd17, 32'hFFFF_FFFF);
    loadReg(5'd18, 32'hFFFF_FFFF);
    loadReg(5'd19, 32'hFFFF_FFFF);

    // R1/R2: table is all zero after reset, so a branch is scalar
    issue(brWord(7'd0, 5'd8, 5'd1, 3'b000, 5'd16, 7'b1100011));
    check("R2 scalarBranch pulse", {31'b0, scalarBranch}, 32'h1);
    check("R1 not busy on scalar", {31'b0, busy}, 32'h0);
    @(negedge clk);
    check("R2 scalarBranch one cycle", {31'b0, scalarBranch}, 32'h0);
    readReg(5'd16, v);
    check("R2 no write on scalar", v, 32'h1234_5678);

    setLen(5'd1, 4'd4); setLen(5'd8, 4'd4); setLen(5'd12, 4'd2);
    setLen(5'd30, 4'd4); setLen(5'd22, 4'd1);

    // R3: non-branch opcode with a vector source is ignored
    issue(brWord(7'd0, 5'd8, 5'd1, 3'b000, 5'd19, 7'b0110011));
    for (int k = 0; k < 6; k++) begin
      check("R3 no activity", {29'b0, busy, done, scalarBranch | illegalOp}, 32'h0);
      @(negedge clk);
    end
    readReg(5'd19, v);
    check("R3 target untouched", v, 32'hFFFF_FFFF);

    // R8: illegal funct3 and reserved bits
    issue(brWord(7'd0, 5'd8, 5'd1, 3'b010, 5'd19, 7'b1100011));
    check("R8 illegalOp funct3 010", {30'b0, illegalOp, busy}, 32'h2);
    issue(brWord(7'd0, 5'd8, 5'd1, 3'b011, 5'd19, 7'b1100011));
    check("R8 illegalOp funct3 011", {30'b0, illegalOp, busy}, 32'h2);
    issue(brWord(7'h40, 5'd8, 5'd1, 3'b000, 5'd19, 7'b1100011));
    check("R8 illegalOp reserved bits", {30'b0, illegalOp, busy}, 32'h2);
    repeat (3) @(negedge clk);
    readReg(5'd19, v);
    check("R8 no write", v, 32'hFFFF_FFFF);

    // Table of vector compares (R4 R5 R6 R7 R9 R11)
    for (int i = 0; i < NV; i++) begin
      issue(brWord(7'd0, TBL[i].b, TBL[i].a, TBL[i].f3, TBL[i].d, 7'b1100011));
      check("R4 busy after accept", {31'b0, busy}, 32'h1);
      waitDone(n);
      check("R4 edges to done equals VL", n, 32'(TBL[i].vl));
      check("R4 idle after write", {31'b0, busy}, 32'h0);
      readReg(TBL[i].d, v);
      check($sformatf("R7 R9 R5 R6 R11 predicate row %0d", i), v, TBL[i].exp);
    end

    // R10: writes to register 0 discarded, reads zero
    loadReg(5'd0, 32'hDEAD_BEEF);
    readReg(5'd0, v);
    check("R10 load to x0 discarded", v, 32'h0);
    issue(brWord(7'd0, 5'd8, 5'd1, 3'b000, 5'd0, 7'b1100011));
    waitDone(n);
    check("R10 predicate walk to x0 length", n, 32'd4);
    readReg(5'd0, v);
    check("R10 predicate to x0 discarded", v, 32'h0);

    finishRun();
  end
endmodule